// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block collects the interrupt sources of a 16550-style UART and masks each one with an interrupt-enable byte. It reports the most urgent pending source as an identification byte and drives one interrupt line. There are five sources: receiver line-status errors, received data reaching the trigger level, receive character timeout, transmit holding register empty, and modem status changes. The block sees the raw conditions and the receive FIFO fill level, plus read and write strobes from the register decoder. It decides when each pending condition is raised and when it is dropped.

Line-status, holding-empty and modem sources are latched. Their enable bits only gate the reported view, so a condition that arrives while masked shows up once its enable bit is set. Data-available follows the FIFO level directly. Timeout comes from a counter of character-time ticks. The FIFO, the serial engines and the bus decoding are outside this block.

Top module: `uart_irq_ident`

## Requirements
- R1: Reset clears the enable register. A write stores data bits 3:0: bit 0 enables data-available and timeout, bit 1 holding-empty, bit 2 line status and bit 3 modem status. The readback `ier_o` always shows bits 7:4 as 0.
- R2: With no enabled source pending, the identification byte has bit 0 = 1 and bits 3:1 = 000, and `irq_o` is low. Bits 5:4 always read 0. The reset value is 0x01.
- R3: Bits 7:6 of the identification byte read 11 while FIFO mode is on and 00 while it is off.
- R4: A line-status error pulse is latched. When enabled, it reports code 011. An LSR read with no new error clears it at the next edge.
- R5: Data-available (code 010) is active in the same cycle the FIFO level is at or above the trigger. In FIFO mode the select values 00/01/10/11 give triggers of 1/4/8/14. With FIFO mode off the trigger is 1.
- R6: In FIFO mode, a non-empty FIFO that sees 4 character-time ticks with no new character and no data read reports code 110. A data read, a new character or an empty FIFO clears it. Data-available outranks timeout.
- R7: A rising edge of the holding-empty condition latches a pending flag, which reports code 001. A THR write clears it. An identification read clears it when 001 is the code being reported.
- R8: An identification read while another source is reported leaves the holding-empty flag pending.
- R9: A modem-status delta pulse is latched and reports code 000 with bit 0 = 0. An MSR read with no new delta clears it.
- R10: Priority from highest to lowest is line status, then data-available/timeout, then holding-empty, then modem status.
- R11: `irq_o` is high exactly when an enabled source is pending. A latched source that arrives while masked is reported once it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ier_wr_i | input | 1 | Enable register write strobe |
| wdata_i | input | 8 | Enable register write data |
| ier_o | output | 8 | Enable register readback |
| fifo_en_i | input | 1 | FIFO mode on |
| trig_sel_i | input | 2 | Receive trigger select |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| rx_char_i | input | 1 | Character received pulse |
| char_tick_i | input | 1 | One pulse per character time |
| lsr_err_i | input | 1 | Line error event pulse |
| thr_empty_i | input | 1 | Holding register empty level |
| msr_delta_i | input | 1 | Modem status change pulse |
| iir_rd_i | input | 1 | Identification read strobe |
| lsr_rd_i | input | 1 | Line status read strobe |
| rbr_rd_i | input | 1 | Receive data read strobe |
| thr_wr_i | input | 1 | Holding register write strobe |
| msr_rd_i | input | 1 | Modem status read strobe |
| iir_o | output | 8 | Identification byte |
| irq_o | output | 1 | Interrupt output |

## Verification
The assertions check on every cycle that the interrupt line agrees with the pending bit and that the reserved and FIFO-mode bits are right. They also check that line-status, modem and holding-empty sources drop after their clearing strobe. Finally they check that a lower-priority code never hides an enabled data-available condition. The bench scenarios cover the rest. They sweep every trigger select against every FIFO level and count character ticks up to the timeout. They show how an identification read behaves when holding-empty is or is not the reported code, and that a masked latch is reported once its enable bit is set.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC = 5;
  // source index order is also priority order (0 = highest)
  localparam int S_LS   = 0;
  localparam int S_RDA  = 1;
  localparam int S_TO   = 2;
  localparam int S_THRE = 3;
  localparam int S_MS   = 4;

  localparam logic [2:0] ID_LS   = 3'b011;
  localparam logic [2:0] ID_RDA  = 3'b010;
  localparam logic [2:0] ID_TO   = 3'b110;
  localparam logic [2:0] ID_THRE = 3'b001;
  localparam logic [2:0] ID_MS   = 3'b000;

  function automatic logic [2:0] src_id(input int idx);
    case (idx)
      S_LS:    return ID_LS;
      S_RDA:   return ID_RDA;
      S_TO:    return ID_TO;
      S_THRE:  return ID_THRE;
      default: return ID_MS;
    endcase
  endfunction

  function automatic int unsigned trig_level(input logic fifo_en, input logic [1:0] sel);
    if (!fifo_en) return 1;
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_latches.sv
module uart_irq_latches (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lsr_err_i,
  input  logic lsr_rd_i,
  input  logic thr_empty_i,
  input  logic thr_wr_i,
  input  logic iir_rd_i,
  input  logic thre_rep_i,
  input  logic msr_delta_i,
  input  logic msr_rd_i,
  output logic ls_o,
  output logic thre_o,
  output logic ms_o
);
  logic empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ls_o    <= 1'b0;
      thre_o  <= 1'b0;
      ms_o    <= 1'b0;
      empty_q <= 1'b1; // no spurious edge right after reset
    end else begin
      empty_q <= thr_empty_i;
      if (lsr_err_i)     ls_o <= 1'b1;
      else if (lsr_rd_i) ls_o <= 1'b0;
      if (msr_delta_i)   ms_o <= 1'b1;
      else if (msr_rd_i) ms_o <= 1'b0;
      if (thr_wr_i || (iir_rd_i && thre_rep_i)) thre_o <= 1'b0;
      else if (thr_empty_i && !empty_q)         thre_o <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout #(
  parameter int TO_CHARS = 4,
  parameter int LVL_W    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic             rx_char_i,
  input  logic             rbr_rd_i,
  input  logic             char_tick_i,
  output logic             timeout_o
);
  localparam int CW = $clog2(TO_CHARS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TO_CHARS);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!fifo_en_i || rx_level_i == '0 || rx_char_i || rbr_rd_i) cnt_q <= '0;
    else if (char_tick_i && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign timeout_o = (cnt_q == LIMIT);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] pend_i,
  output logic [2:0]      id_o,
  output logic            any_o
);
  always_comb begin
    id_o = ID_MS;
    // scan lowest priority first so the highest pending source wins
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend_i[i]) id_o = src_id(i);
    end
  end
  assign any_o = |pend_i;
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int TO_CHARS   = 4,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ier_wr_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       ier_o,
  input  logic             fifo_en_i,
  input  logic [1:0]       trig_sel_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic             rx_char_i,
  input  logic             char_tick_i,
  input  logic             lsr_err_i,
  input  logic             thr_empty_i,
  input  logic             msr_delta_i,
  input  logic             iir_rd_i,
  input  logic             lsr_rd_i,
  input  logic             rbr_rd_i,
  input  logic             thr_wr_i,
  input  logic             msr_rd_i,
  output logic [7:0]       iir_o,
  output logic             irq_o
);
  logic [3:0]      ier_q;
  logic            ls, thre, ms, to, rda, any;
  logic [2:0]      id;
  logic [NSRC-1:0] pend;
  logic            thre_rep;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ier_q <= '0;
    else if (ier_wr_i) ier_q <= wdata_i[3:0];
  end
  assign ier_o = {4'b0000, ier_q};

  assign rda = 32'(rx_level_i) >= trig_level(fifo_en_i, trig_sel_i);

  uart_irq_latches u_latch (
    .clk_i, .rst_ni,
    .lsr_err_i, .lsr_rd_i, .thr_empty_i, .thr_wr_i, .iir_rd_i,
    .thre_rep_i (thre_rep),
    .msr_delta_i, .msr_rd_i,
    .ls_o (ls), .thre_o (thre), .ms_o (ms)
  );

  uart_irq_timeout #(.TO_CHARS(TO_CHARS), .LVL_W(LVL_W)) u_to (
    .clk_i, .rst_ni, .fifo_en_i, .rx_level_i, .rx_char_i, .rbr_rd_i, .char_tick_i,
    .timeout_o (to)
  );

  always_comb begin
    pend         = '0;
    pend[S_LS]   = ls   & ier_q[2];
    pend[S_RDA]  = rda  & ier_q[0];
    pend[S_TO]   = to   & ier_q[0];
    pend[S_THRE] = thre & ier_q[1];
    pend[S_MS]   = ms   & ier_q[3];
  end

  uart_irq_prio u_prio (.pend_i(pend), .id_o(id), .any_o(any));

  assign thre_rep = any && (id == ID_THRE);
  assign iir_o    = {{2{fifo_en_i}}, 2'b00, id, ~any};
  assign irq_o    = any;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk
  import uart_irq_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [7:0]       ier_o,
  input logic             fifo_en_i,
  input logic [1:0]       trig_sel_i,
  input logic [LVL_W-1:0] rx_level_i,
  input logic             lsr_err_i,
  input logic             lsr_rd_i,
  input logic             msr_delta_i,
  input logic             msr_rd_i,
  input logic             thr_wr_i,
  input logic [7:0]       iir_o,
  input logic             irq_o
);
  assert_irq_vs_pend_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == !iir_o[0]);

  assert_reserved_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iir_o[5:4] == 2'b00 && ier_o[7:4] == 4'h0);

  assert_fifo_bits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iir_o[7:6] == {2{fifo_en_i}});

  assert_ls_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_rd_i && !lsr_err_i) |=> !(iir_o[3:1] == ID_LS && !iir_o[0]));

  assert_ms_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msr_rd_i && !msr_delta_i) |=> !(iir_o[3:1] == ID_MS && !iir_o[0]));

  assert_thre_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_wr_i |=> !(iir_o[3:1] == ID_THRE && !iir_o[0]));

  assert_rda_not_hidden_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!iir_o[0] && (iir_o[3:1] == ID_THRE || iir_o[3:1] == ID_MS))
      |-> !(ier_o[0] && 32'(rx_level_i) >= trig_level(fifo_en_i, trig_sel_i)));
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.LVL_W(LVL_W)) u_chk (
  .clk_i, .rst_ni, .ier_o, .fifo_en_i, .trig_sel_i, .rx_level_i,
  .lsr_err_i, .lsr_rd_i, .msr_delta_i, .msr_rd_i, .thr_wr_i, .iir_o, .irq_o
);

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;
  localparam int CLK_PERIOD = 10;
  localparam int LVL_W = 5;

  logic clk_i = 0, rst_ni = 0;
  logic ier_wr_i = 0; logic [7:0] wdata_i = 0; logic [7:0] ier_o;
  logic fifo_en_i = 0; logic [1:0] trig_sel_i = 0; logic [LVL_W-1:0] rx_level_i = 0;
  logic rx_char_i = 0, char_tick_i = 0, lsr_err_i = 0, thr_empty_i = 1, msr_delta_i = 0;
  logic iir_rd_i = 0, lsr_rd_i = 0, rbr_rd_i = 0, thr_wr_i = 0, msr_rd_i = 0;
  logic [7:0] iir_o; logic irq_o;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  uart_irq_ident dut (.*);

  task automatic step(); @(posedge clk_i); #1; endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_iir(logic f, logic [2:0] code, logic p);
    return {{2{f}}, 2'b00, code, ~p};
  endfunction

  task automatic chk_iir(string req, logic [2:0] code, logic p);
    #1;
    chk(req, iir_o, exp_iir(fifo_en_i, code, p));
    chk(req, irq_o, p);
  endtask

  task automatic set_ier(logic [7:0] v);
    wdata_i = v; ier_wr_i = 1; step(); ier_wr_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int trig;
    step(); step(); rst_ni = 1; step();
    // reset state
    chk("R2 reset iir", iir_o, 8'h01);
    chk("R2 reset irq", irq_o, 0);
    chk("R1 reset ier", ier_o, 0);

    // R1 enable register sweep
    for (int v = 0; v < 256; v++) begin
      set_ier(8'(v));
      chk("R1 ier", ier_o, v & 8'h0F);
    end
    set_ier(0);

    // R3 mode bits
    chk_iir("R3 fifo off", 3'b000, 0);
    fifo_en_i = 1;
    chk_iir("R3 fifo on", 3'b000, 0);

    // R5 trigger sweep
    set_ier(8'h01);
    for (int f = 0; f < 2; f++) begin
      fifo_en_i = f[0];
      for (int s = 0; s < 4; s++) begin
        trig_sel_i = 2'(s);
        trig = !f ? 1 : (s == 0 ? 1 : s == 1 ? 4 : s == 2 ? 8 : 14);
        for (int l = 0; l <= 16; l++) begin
          rx_level_i = LVL_W'(l);
          chk_iir("R5 rda", (l >= trig) ? 3'b010 : 3'b000, l >= trig);
        end
      end
    end
    fifo_en_i = 1; trig_sel_i = 0;

    // R11 masking of live source
    rx_level_i = 5; set_ier(0);
    chk_iir("R11 masked rda", 3'b000, 0);
    rx_level_i = 0; step();

    // R4 line status, R10 over rda
    set_ier(8'h05);
    lsr_err_i = 1; step(); lsr_err_i = 0;
    chk_iir("R4 ls set", 3'b011, 1);
    rx_level_i = 3;
    chk_iir("R10 ls over rda", 3'b011, 1);
    lsr_rd_i = 1; step(); lsr_rd_i = 0;
    chk_iir("R4 ls clear", 3'b010, 1);
    rx_level_i = 0; step();

    // R11 latched while masked
    set_ier(0);
    lsr_err_i = 1; step(); lsr_err_i = 0;
    chk_iir("R11 latched hidden", 3'b000, 0);
    set_ier(8'h04);
    chk_iir("R11 latched shown", 3'b011, 1);
    lsr_rd_i = 1; step(); lsr_rd_i = 0;
    chk_iir("R4 ls clear2", 3'b000, 0);

    // R7 holding empty
    set_ier(8'h02);
    thr_empty_i = 0; step(); thr_empty_i = 1; step();
    chk_iir("R7 thre set", 3'b001, 1);
    iir_rd_i = 1; step(); iir_rd_i = 0;
    chk_iir("R7 thre iir read clear", 3'b000, 0);
    thr_empty_i = 0; step(); thr_empty_i = 1; step();
    chk_iir("R7 thre set2", 3'b001, 1);
    thr_wr_i = 1; step(); thr_wr_i = 0;
    chk_iir("R7 thre write clear", 3'b000, 0);

    // R8 iir read while ls reported
    set_ier(8'h06);
    thr_empty_i = 0; step(); thr_empty_i = 1;
    lsr_err_i = 1; step(); lsr_err_i = 0;
    chk_iir("R10 ls over thre", 3'b011, 1);
    iir_rd_i = 1; step(); iir_rd_i = 0;
    lsr_rd_i = 1; step(); lsr_rd_i = 0;
    chk_iir("R8 thre kept", 3'b001, 1);

    // R9 modem status, R10 thre over ms
    set_ier(8'h0A);
    msr_delta_i = 1; step(); msr_delta_i = 0;
    chk_iir("R10 thre over ms", 3'b001, 1);
    thr_wr_i = 1; step(); thr_wr_i = 0;
    chk_iir("R9 ms set", 3'b000, 1);
    msr_rd_i = 1; step(); msr_rd_i = 0;
    chk_iir("R9 ms clear", 3'b000, 0);

    // R6 timeout
    set_ier(8'h01); trig_sel_i = 2'd3; rx_level_i = 2; step();
    for (int k = 0; k < 3; k++) begin
      char_tick_i = 1; step(); char_tick_i = 0;
      chk_iir("R6 before limit", 3'b000, 0);
    end
    char_tick_i = 1; step(); char_tick_i = 0;
    chk_iir("R6 timeout set", 3'b110, 1);
    rbr_rd_i = 1; step(); rbr_rd_i = 0;
    chk_iir("R6 read clear", 3'b000, 0);
    for (int k = 0; k < 3; k++) begin char_tick_i = 1; step(); char_tick_i = 0; end
    rx_char_i = 1; step(); rx_char_i = 0;
    for (int k = 0; k < 3; k++) begin char_tick_i = 1; step(); char_tick_i = 0; end
    chk_iir("R6 new char restarts", 3'b000, 0);
    char_tick_i = 1; step(); char_tick_i = 0;
    chk_iir("R6 timeout set2", 3'b110, 1);
    rx_level_i = 14;
    chk_iir("R6 rda outranks", 3'b010, 1);
    rx_level_i = 0; step();
    chk_iir("R6 empty clear", 3'b000, 0);
    fifo_en_i = 0; rx_level_i = 0; set_ier(0);
    fifo_en_i = 0; step();
    rx_level_i = 2; fifo_en_i = 0; set_ier(8'h00);
    for (int k = 0; k < 5; k++) begin char_tick_i = 1; step(); char_tick_i = 0; end
    set_ier(8'h01); trig_sel_i = 2'd3;
    rx_level_i = 0;
    chk_iir("R6 no timeout fifo off", 3'b000, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule